// File: doc/BRIEF.md
# Jittered Periodic Pulse Source

This block stands in for one healthy sensor on a data bus. It produces a one-clock data strobe once per nominal period of `PERIOD` clock ticks. Each strobe may land anywhere inside a tolerance window that spans `JITTER` ticks either side of the nominal period boundary. A programmable placement input picks the slot inside the window. A suppress input can drop the strobe of a window, which models a lost message. A second output, the window flag, is high while a window is open.

Time counts in ticks from the first clock after reset release. Tick 0 is a period boundary. Slot `s` of the window around boundary `n` (n ≥ 1) is tick `n*PERIOD - JITTER + s`, for `s` from 0 to `2*JITTER`. The window around boundary 0 has only its upper half, ticks 0 to `JITTER`. The design requires `2*JITTER < PERIOD`.

Top module: `jitter_pulse_src`

## Requirements
- R1: `window_o` is high at tick k exactly when (k mod PERIOD) ≤ JITTER or (k mod PERIOD) ≥ PERIOD−JITTER. While reset is held, `window_o` is 1 and `strobe_o` is 0.
- R2: `strobe_o` is never high while `window_o` is low.
- R3: Each window carries at most one strobe. Any two strobes are therefore at least PERIOD−2·JITTER ticks apart.
- R4: If the placement input holds a constant value s ≤ 2·JITTER, the strobe of the window around boundary n (n ≥ 1) appears at tick n·PERIOD−JITTER+s.
- R5: A placement value above 2·JITTER is treated as 2·JITTER. The strobe then lands at tick n·PERIOD+JITTER.
- R6: In the window around boundary 0, the strobe appears at tick max(1, s−JITTER), where s is the clamped placement.
- R7: If `drop_i` is high in the tick just before the tick a strobe would appear, that window produces no strobe. Later windows keep their normal timing.
- R8: `strobe_o` is high for exactly one clock (this holds whenever PERIOD−2·JITTER > 1).
- R9: The placement input is sampled each tick and applies to the following tick. Within an open window, the strobe appears at the first tick whose slot is at or beyond the placement seen in the tick before. Lowering the placement mid-window therefore brings the strobe forward to the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offset_i | input | OFS_W | Slot within the window at which to emit |
| drop_i | input | 1 | Suppress the strobe due on the next tick |
| strobe_o | output | 1 | One-clock data strobe |
| window_o | output | 1 | High while a tolerance window is open |

## Verification
Suppression and the emit decision can fall in the same cycle. The bench raises `drop_i` only in the single tick before a strobe is due. It does this once at a mid-window slot and once at the last slot of a window. It then expects that window to stay silent and the next window to fire on time. Placement changes and the emit decision also meet in one cycle. This is provoked by lowering the placement below the current slot mid-window, which must pull the strobe to the next tick. A pseudo-random walk of the placement then checks that spacing never drops below PERIOD−2·JITTER.

// File: rtl/jps_pkg.sv
package jps_pkg;

    // True when a phase value lies inside the tolerance window
    function automatic logic in_window(int ph, int per, int jit);
        return (ph <= jit) || (ph >= per - jit);
    endfunction

    // Slot index inside the window for a phase value that lies in it
    function automatic int slot_of(int ph, int per, int jit);
        return (ph >= per - jit) ? ph - (per - jit) : ph + jit;
    endfunction

    // Limit a requested slot to the last slot of the window
    function automatic int clamp_slot(int req, int last);
        return (req > last) ? last : req;
    endfunction

endpackage

// File: rtl/jps_phase.sv
module jps_phase
    import jps_pkg::*;
#(
    parameter int PERIOD = 12,
    parameter int JITTER = 3,
    parameter int PH_W   = 4,
    parameter int POS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             win_o,
    output logic             nxt_open_o,
    output logic             nxt_start_o,
    output logic [POS_W-1:0] nxt_pos_o
);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            win;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (int'(st_q.ph) == PERIOD - 1) begin
            st_d.ph = '0;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
        st_d.win    = in_window(int'(st_d.ph), PERIOD, JITTER);
        nxt_open_o  = st_d.win;
        nxt_start_o = (int'(st_d.ph) == PERIOD - JITTER);
        nxt_pos_o   = POS_W'(slot_of(int'(st_d.ph), PERIOD, JITTER));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: '0, win: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o = st_q.win;

endmodule

// File: rtl/jps_pick.sv
module jps_pick
    import jps_pkg::*;
#(
    parameter int JITTER = 3,
    parameter int OFS_W  = 4,
    parameter int POS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] offset_i,
    input  logic             drop_i,
    input  logic             nxt_open_i,
    input  logic             nxt_start_i,
    input  logic [POS_W-1:0] nxt_pos_i,
    output logic             strobe_o
);

    localparam int LAST_SLOT = 2 * JITTER;

    typedef struct packed {
        logic fired;
        logic strobe;
    } pick_t;

    pick_t            st_d, st_q;
    logic [POS_W-1:0] eff_slot;
    logic             used_d;
    logic             fire_d;

    always_comb begin
        st_d     = st_q;
        eff_slot = POS_W'(clamp_slot(int'(offset_i), LAST_SLOT));
        // a fresh window clears the one-shot
        used_d   = nxt_start_i ? 1'b0 : st_q.fired;
        fire_d   = nxt_open_i && !used_d && (nxt_pos_i >= eff_slot);
        st_d.fired  = used_d | fire_d;
        st_d.strobe = fire_d & ~drop_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fired: 1'b0, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;

endmodule

// File: rtl/jitter_pulse_src.sv
module jitter_pulse_src #(
    parameter int PERIOD = 12,
    parameter int JITTER = 3,
    parameter int OFS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] offset_i,
    input  logic             drop_i,
    output logic             strobe_o,
    output logic             window_o
);

    localparam int PH_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int POS_W = $clog2(2 * JITTER + 2);

    logic             nxt_open;
    logic             nxt_start;
    logic [POS_W-1:0] nxt_pos;

    jps_phase #(
        .PERIOD(PERIOD),
        .JITTER(JITTER),
        .PH_W  (PH_W),
        .POS_W (POS_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_o      (window_o),
        .nxt_open_o (nxt_open),
        .nxt_start_o(nxt_start),
        .nxt_pos_o  (nxt_pos)
    );

    jps_pick #(
        .JITTER(JITTER),
        .OFS_W (OFS_W),
        .POS_W (POS_W)
    ) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .offset_i   (offset_i),
        .drop_i     (drop_i),
        .nxt_open_i (nxt_open),
        .nxt_start_i(nxt_start),
        .nxt_pos_i  (nxt_pos),
        .strobe_o   (strobe_o)
    );

endmodule

// File: rtl/jps_check.sv
module jps_check #(
    parameter int P = 12,
    parameter int J = 3
) (
    input logic clk,
    input logic rst_n,
    input logic strobe,
    input logic window
);

    localparam int TW = (P > 1) ? $clog2(P) : 1;

    logic [TW-1:0] tk_q;
    logic [TW:0]   gap_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_q   <= '0;
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            tk_q <= (int'(tk_q) == P - 1) ? '0 : tk_q + 1'b1;
            if (strobe) begin
                gap_q  <= (TW+1)'(1);
                seen_q <= 1'b1;
            end else if (int'(gap_q) < P) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assert_win_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        window == ((int'(tk_q) <= J) || (int'(tk_q) >= P - J)));

    assert_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> window);

    assert_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && seen_q) |-> (int'(gap_q) >= P - 2 * J));

    assert_one_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((P - 2 * J > 1) && strobe) |=> !strobe);

endmodule

bind jitter_pulse_src jps_check #(.P(PERIOD), .J(JITTER)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(strobe_o),
    .window(window_o)
);

// File: tb/jitter_pulse_src_test.sv
`timescale 1ns/1ps
module jitter_pulse_src_test;

    localparam int P  = 12;
    localparam int J  = 3;
    localparam int OW = 4;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [OW-1:0] ofs   = '0;
    logic          drop  = 1'b0;
    logic          strobe;
    logic          win;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    jitter_pulse_src #(.PERIOD(P), .JITTER(J), .OFS_W(OW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .offset_i(ofs),
        .drop_i  (drop),
        .strobe_o(strobe),
        .window_o(win)
    );

    function automatic int clampo(int o);
        return (o > 2 * J) ? 2 * J : o;
    endfunction

    function automatic int win_of(int k);
        return (k <= J) ? 0 : (k + J) / P;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drop  = 1'b0;
        repeat (2) @(negedge clk);
        check(strobe == 1'b0, "R1", "strobe in reset", int'(strobe), 0);
        check(win == 1'b1, "R1", "window in reset", int'(win), 1);
        rst_n = 1'b1;
    endtask

    // spacing, width and window checks on each strobe (R2, R3, R8)
    task automatic strobe_rules(int k, bit prev, inout int last);
        if (strobe) begin
            check(win == 1'b1, "R2", "strobe outside window", int'(win), 1);
            check(!prev, "R8", "strobe wider than one clock", 1, 0);
            if (last >= 0)
                check(k - last >= P - 2 * J, "R3", "strobe spacing", k - last, P - 2 * J);
            last = k;
        end
    endtask

    task automatic run_case(int o, int dlo, int dhi, int chg_at, int chg_o,
                            int wsp, int tsp, int n, string tag);
        int last = -1;
        bit prev = 0;
        do_reset();
        ofs = OW'(o);
        for (int k = 0; k < n; k++) begin
            int    w  = win_of(k);
            int    ph = k % P;
            int    e;
            int    et;
            string t;
            e = (chg_at >= 0 && w > wsp) ? clampo(chg_o) : clampo(o);
            if (w == wsp)      et = tsp;
            else if (w == 0)   et = (e - J > 1) ? e - J : 1;
            else               et = w * P - J + e;
            if (w == wsp)      t = tag;
            else if (w == 0)   t = "R6";
            else if (o > 2*J)  t = "R5";
            else               t = "R4";
            check(win == ((ph <= J) || (ph >= P - J)), "R1", "window phase",
                  int'(win), int'((ph <= J) || (ph >= P - J)));
            check(strobe == (k == et), t, $sformatf("strobe at tick %0d", k),
                  int'(strobe), int'(k == et));
            strobe_rules(k, prev, last);
            prev = strobe;
            drop = (k >= dlo && k <= dhi);
            if (chg_at >= 0 && k >= chg_at) ofs = OW'(chg_o);
            @(posedge clk);
            @(negedge clk);
        end
        drop = 1'b0;
    endtask

    task automatic run_wander(int n);
        int       last = -1;
        bit       prev = 0;
        logic [7:0] lf = 8'h5a;
        do_reset();
        for (int k = 0; k < n; k++) begin
            int ph = k % P;
            check(win == ((ph <= J) || (ph >= P - J)), "R1", "window phase (wander)",
                  int'(win), int'((ph <= J) || (ph >= P - J)));
            strobe_rules(k, prev, last);
            prev = strobe;
            lf   = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            ofs  = lf[OW-1:0];
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        // constant placement sweep, including clamped values (R4, R5, R6)
        for (int o = 0; o < (1 << OW); o++)
            run_case(o, -1, -1, -1, 0, -1, -1, 64, "R4");
        // drop only in the decision tick, mid-window slot (R7)
        run_case(2, 2*P - J + 1, 2*P - J + 1, -1, 0, 2, -1, 64, "R7");
        // drop only in the decision tick, last slot (R7)
        run_case(6, P + J - 1, P + J - 1, -1, 0, 1, -1, 64, "R7");
        // placement lowered below current slot mid-window (R9)
        run_case(5, -1, -1, 11, 1, 1, 12, 64, "R9");
        // random placement walk (R2, R3, R8)
        run_wander(480);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule